// File: doc/BRIEF.md
# Keyboard Scan-Code Keystroke Decoder

This block sits behind a serial keyboard frame receiver. The receiver hands it one byte at a time with a one-cycle valid strobe and can flag a damaged frame with an error strobe. The decoder groups the bytes into keystrokes. A keystroke is a plain make byte, a release (prefix F0 then the code), an extended make (prefix E0 then the code) or an extended release (E0, F0, then the code). When a keystroke is complete, the decoder publishes the code with two flags: extended and release.

A published keystroke raises `new_key`. The code and flags stay frozen until the consumer pulses `ack`. If a fresh keystroke completes before the old one was acknowledged, the fresh one replaces it and `overrun` is raised. The prefix bytes are swallowed and never appear as codes, so every keystroke starts on the right byte. A pause-key prefix makes the decoder step over the rest of that long sequence.

Top module: `kbd_seq_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, `new_key`, `overrun`, `key_ext`, `key_brk` are 0 and `key_code` is 8'h00.
- R2: A byte other than E0, F0 or E1, accepted (`rx_valid`=1, `rx_err`=0) with no prefix pending, is published on the next clock edge as `key_code`, with `key_ext`=0, `key_brk`=0 and `new_key`=1.
- R3: Byte F0 followed by a code publishes that code with `key_brk`=1 and `key_ext`=0. F0 is never published as a code, and further F0 bytes while waiting keep the release pending.
- R4: Byte E0 followed by a code publishes it with `key_ext`=1 and `key_brk`=0. A repeated E0 keeps the extended prefix pending.
- R5: The sequence E0, F0, code publishes the code with `key_ext`=1 and `key_brk`=1.
- R6: While `new_key`=1 and no new keystroke completes, `key_code`, `key_ext` and `key_brk` hold. A cycle with `ack`=1 clears `new_key` and `overrun` on the next edge. `ack` with `new_key`=0 changes nothing.
- R7: A keystroke that completes while `new_key`=1 and `ack`=0 overwrites the held code and sets `overrun`=1. If `ack`=1 in that same cycle, the new keystroke is published with `overrun`=0.
- R8: `rx_err`=1 drops any pending prefix and any pause skip, and produces no keystroke. The next accepted byte starts a new sequence.
- R9: Byte E0 arriving while a release (F0) is pending cancels the sequence without a keystroke.
- R10: Byte E1 outside a pause skip publishes nothing, and the following 7 accepted bytes publish nothing. The byte after those starts a new sequence.
- R11: A byte presented with `rx_valid`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_byte | input | 8 | Byte from the frame receiver |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_err | input | 1 | One-cycle strobe: the receiver saw a bad frame |
| ack | input | 1 | Consumer has taken the published keystroke |
| key_code | output | 8 | Code of the last keystroke |
| key_ext | output | 1 | Keystroke carried the extended prefix |
| key_brk | output | 1 | Keystroke is a release |
| new_key | output | 1 | Unacknowledged keystroke available |
| overrun | output | 1 | A held keystroke was overwritten before acknowledge |

## Verification
The properties assume that `rx_valid` and `rx_err` are single-cycle strobes sampled on the clock edge, and that `ack` is an ordinary level that may coincide with a completing keystroke. The overwrite and hold checks are then judged against the decoder's internal completion strobe, not against the raw byte stream. The stimulus changes every input only on the falling clock edge. It presents each byte for exactly one cycle with idle gaps, raises the error strobe only between bytes, and deliberately lines `ack` up with a completing keystroke once, so that the same-cycle rule is covered.

// File: rtl/kbd_pkg.sv
// Shared definitions for the keystroke decoder.
// Assumes scan-code set 2 byte values for the three prefixes.
package kbd_pkg;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] PFX_EXT   = 8'hE0;
    localparam logic [CODE_W-1:0] PFX_REL   = 8'hF0;
    localparam logic [CODE_W-1:0] PFX_PAUSE = 8'hE1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_REL,
        ST_EXT_REL
    } parse_st_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic              brk;
    } key_evt_t;
endpackage

// File: rtl/kbd_skip_cnt.sv
// Pause-sequence skipper: once loaded, swallows the next SKIP_LEN
// accepted bytes. Assumes load and step never happen in the same cycle
// for a byte other than the loading one (load wins).
module kbd_skip_cnt #(
    parameter int SKIP_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic clear,
    output logic active
);
    localparam int CW = $clog2(SKIP_LEN + 1);

    logic [CW-1:0] remain;

    // Count down the bytes still to be discarded.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(SKIP_LEN);
        end else if (step && remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign active = (remain != '0);
endmodule

// File: rtl/kbd_prefix_fsm.sv
// Prefix parser: tracks E0/F0 prefixes and flags a completed keystroke
// combinationally in the cycle its final byte is accepted.
// Assumes rx_valid/rx_err are single-cycle strobes; rx_err takes priority.
module kbd_prefix_fsm
    import kbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic              skipping,
    output logic              evt_valid,
    output key_evt_t          evt,
    output logic              pause_start
);
    parse_st_t st, st_nxt;
    logic      take;

    assign take = rx_valid && !rx_err && !skipping;

    // Decide the next parse state and whether this byte ends a keystroke.
    always_comb begin
        st_nxt      = st;
        evt_valid   = 1'b0;
        pause_start = 1'b0;
        evt.code    = rx_byte;
        evt.ext     = (st == ST_EXT) || (st == ST_EXT_REL);
        evt.brk     = (st == ST_REL) || (st == ST_EXT_REL);
        if (rx_err) begin
            st_nxt = ST_IDLE;
        end else if (take) begin
            if (rx_byte == PFX_PAUSE) begin
                pause_start = 1'b1;
                st_nxt      = ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (rx_byte == PFX_EXT) begin
                            st_nxt = ST_EXT;
                        end else if (rx_byte == PFX_REL) begin
                            st_nxt = ST_REL;
                        end else begin
                            evt_valid = 1'b1;
                        end
                    end
                    ST_EXT: begin
                        if (rx_byte == PFX_REL) begin
                            st_nxt = ST_EXT_REL;
                        end else if (rx_byte != PFX_EXT) begin
                            evt_valid = 1'b1;
                            st_nxt    = ST_IDLE;
                        end
                    end
                    default: begin
                        if (rx_byte == PFX_EXT) begin
                            st_nxt = ST_IDLE;
                        end else if (rx_byte != PFX_REL) begin
                            evt_valid = 1'b1;
                            st_nxt    = ST_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    // Hold the parse state between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end
endmodule

// File: rtl/kbd_event_hold.sv
// Output holding register with a sticky new-key flag and overrun flag.
// Assumes ack is a level sampled each edge; a completing event wins over ack.
module kbd_event_hold
    import kbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  key_evt_t          evt,
    input  logic              ack,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_brk,
    output logic              new_key,
    output logic              overrun
);
    // Capture completed keystrokes and manage the handshake flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_code <= '0;
            key_ext  <= 1'b0;
            key_brk  <= 1'b0;
            new_key  <= 1'b0;
            overrun  <= 1'b0;
        end else if (evt_valid) begin
            key_code <= evt.code;
            key_ext  <= evt.ext;
            key_brk  <= evt.brk;
            new_key  <= 1'b1;
            overrun  <= new_key && !ack;
        end else if (ack) begin
            new_key  <= 1'b0;
            overrun  <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_seq_decoder.sv
// Top of the keystroke decoder: prefix parser, pause skipper and
// output holding register. Assumes bytes arrive from a frame receiver
// as single-cycle strobes in the clk domain.
module kbd_seq_decoder
    import kbd_pkg::*;
#(
    parameter int SKIP_LEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic              ack,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_brk,
    output logic              new_key,
    output logic              overrun
);
    logic     evt_valid;
    key_evt_t evt;
    logic     pause_start;
    logic     skipping;

    kbd_prefix_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_err     (rx_err),
        .skipping   (skipping),
        .evt_valid  (evt_valid),
        .evt        (evt),
        .pause_start(pause_start)
    );

    kbd_skip_cnt #(.SKIP_LEN(SKIP_LEN)) u_skip (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pause_start),
        .step  (rx_valid && !rx_err),
        .clear (rx_err),
        .active(skipping)
    );

    kbd_event_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(evt_valid),
        .evt      (evt),
        .ack      (ack),
        .key_code (key_code),
        .key_ext  (key_ext),
        .key_brk  (key_brk),
        .new_key  (new_key),
        .overrun  (overrun)
    );
endmodule

// File: rtl/kbd_seq_decoder_chk.sv
// Property checker for the keystroke decoder, bound to the top module.
// Assumes rx_valid/rx_err are single-cycle strobes.
module kbd_seq_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_err,
    input logic       ack,
    input logic       evt_valid,
    input logic       skipping,
    input logic [7:0] key_code,
    input logic       key_ext,
    input logic       key_brk,
    input logic       new_key,
    input logic       overrun
);
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (new_key && !ack && !evt_valid) |=>
            (new_key && $stable(key_code) && $stable(key_ext) && $stable(key_brk)));

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (new_key && ack && !evt_valid) |=> (!new_key && !overrun));

    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (new_key && !ack && evt_valid) |=> (overrun && new_key));

    a_r7_overrun_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> new_key);

    a_r3_no_prefix_code: assert property (@(posedge clk) disable iff (!rst_n)
        new_key |-> (key_code != 8'hF0 && key_code != 8'hE0 && key_code != 8'hE1));

    a_r8_err_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !$rose(new_key));

    a_r10_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> !evt_valid);
endmodule

bind kbd_seq_decoder kbd_seq_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_err   (rx_err),
    .ack      (ack),
    .evt_valid(evt_valid),
    .skipping (skipping),
    .key_code (key_code),
    .key_ext  (key_ext),
    .key_brk  (key_brk),
    .new_key  (new_key),
    .overrun  (overrun)
);

// File: tb/tb_kbd_seq_decoder.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module tb_kbd_seq_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       rx_err = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] key_code;
    logic       key_ext, key_brk, new_key, overrun;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int   m_st = 0;      // 0 none, 1 ext, 2 rel, 3 ext+rel
    int   m_skip = 0;
    logic [7:0] e_code = 8'h00;
    bit   e_ext = 0, e_brk = 0, e_nk = 0, e_ov = 0;

    always #2.5 clk = ~clk;

    kbd_seq_decoder dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_err(rx_err), .ack(ack), .key_code(key_code), .key_ext(key_ext),
        .key_brk(key_brk), .new_key(new_key), .overrun(overrun)
    );

    // Model: step the expected outputs from the requirement text.
    always @(posedge clk) begin
        bit ev;
        bit ex, br;
        ev = 0; ex = 0; br = 0;
        if (!rst_n) begin
            m_st = 0; m_skip = 0; e_code = 8'h00;
            e_ext = 0; e_brk = 0; e_nk = 0; e_ov = 0;
        end else begin
            if (rx_err) begin
                m_st = 0; m_skip = 0;
            end else if (rx_valid) begin
                if (m_skip > 0) begin
                    m_skip = m_skip - 1;
                end else if (rx_byte == 8'hE1) begin
                    m_skip = 7; m_st = 0;
                end else if (rx_byte == 8'hE0) begin
                    if (m_st >= 2) m_st = 0; else m_st = 1;
                end else if (rx_byte == 8'hF0) begin
                    if (m_st == 1 || m_st == 3) m_st = 3; else m_st = 2;
                end else begin
                    ev = 1;
                    ex = (m_st == 1 || m_st == 3);
                    br = (m_st >= 2);
                    m_st = 0;
                end
            end
            if (ev) begin
                e_ov = e_nk && !ack;
                e_nk = 1; e_code = rx_byte; e_ext = ex; e_brk = br;
            end else if (ack) begin
                e_nk = 0; e_ov = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "key_code", key_code, e_code);
            chk(cur_req, "key_ext", key_ext, e_ext);
            chk(cur_req, "key_brk", key_brk, e_brk);
            chk(cur_req, "new_key", new_key, e_nk);
            chk(cur_req, "overrun", overrun, e_ov);
        end
    end

    task automatic send(input logic [7:0] b, input bit with_ack);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1; ack = with_ack;
        @(negedge clk);
        rx_valid = 1'b0; ack = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [7:0] c, input bit x,
                              input bit b, input bit nk, input bit ov);
        chk(req, "key_code", key_code, c);
        chk(req, "key_ext", key_ext, x);
        chk(req, "key_brk", key_brk, b);
        chk(req, "new_key", new_key, nk);
        chk(req, "overrun", overrun, ov);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1", 8'h00, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 8'h00, 0, 0, 0, 0);

        cur_req = "R2";
        send(8'h24, 0);
        expect_out("R2", 8'h24, 0, 0, 1, 0);
        cur_req = "R6";
        repeat (3) @(negedge clk);
        expect_out("R6", 8'h24, 0, 0, 1, 0);
        do_ack();
        expect_out("R6", 8'h24, 0, 0, 0, 0);
        do_ack();
        expect_out("R6", 8'h24, 0, 0, 0, 0);

        cur_req = "R3";
        send(8'hF0, 0);
        expect_out("R3", 8'h24, 0, 0, 0, 0);
        send(8'hF0, 0);
        send(8'h24, 0);
        expect_out("R3", 8'h24, 0, 1, 1, 0);
        do_ack();

        cur_req = "R4";
        send(8'hE0, 0);
        send(8'hE0, 0);
        send(8'h75, 0);
        expect_out("R4", 8'h75, 1, 0, 1, 0);
        do_ack();

        cur_req = "R5";
        send(8'hE0, 0);
        send(8'hF0, 0);
        send(8'h6B, 0);
        expect_out("R5", 8'h6B, 1, 1, 1, 0);
        do_ack();

        cur_req = "R11";
        @(negedge clk); rx_byte = 8'h3D;
        repeat (3) @(negedge clk);
        expect_out("R11", 8'h6B, 1, 1, 0, 0);

        cur_req = "R7";
        send(8'h3D, 0);
        send(8'hF0, 0);
        send(8'h3D, 0);
        expect_out("R7", 8'h3D, 0, 1, 1, 1);
        do_ack();
        expect_out("R7", 8'h3D, 0, 1, 0, 0);
        send(8'h16, 0);
        send(8'h1E, 1);
        expect_out("R7", 8'h1E, 0, 0, 1, 0);
        do_ack();

        cur_req = "R8";
        send(8'hE0, 0);
        send(8'hF0, 0);
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
        expect_out("R8", 8'h1E, 0, 0, 0, 0);
        send(8'h24, 0);
        expect_out("R8", 8'h24, 0, 0, 1, 0);
        do_ack();

        cur_req = "R9";
        send(8'hF0, 0);
        send(8'hE0, 0);
        expect_out("R9", 8'h24, 0, 0, 0, 0);
        send(8'h2D, 0);
        expect_out("R9", 8'h2D, 0, 0, 1, 0);
        do_ack();
        send(8'hE0, 0);
        send(8'hF0, 0);
        send(8'hE0, 0);
        send(8'h75, 0);
        expect_out("R9", 8'h75, 0, 0, 1, 0);
        do_ack();

        cur_req = "R10";
        send(8'hE1, 0);
        send(8'h14, 0);
        send(8'h77, 0);
        send(8'hE1, 0);
        send(8'hF0, 0);
        send(8'h14, 0);
        send(8'hF0, 0);
        send(8'h77, 0);
        expect_out("R10", 8'h75, 0, 0, 0, 0);
        send(8'h3D, 0);
        expect_out("R10", 8'h3D, 0, 0, 1, 0);
        do_ack();

        cur_req = "R8";
        send(8'hE1, 0);
        send(8'h14, 0);
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
        send(8'h1C, 0);
        expect_out("R8", 8'h1C, 0, 0, 1, 0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog %s: actual=timeout expected=finish", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule